// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block maps bus addresses that land inside a graphics aperture onto physical memory pages. The aperture is a 256 MB window chosen by the top 4 address bits. A page inside it is looked up in a remapping table that lives in system memory. The table holds one 32-bit word per 4 KB page, stored least-significant byte first. Bit 0 of the swapped word marks the entry valid, and bits 31:12 give the physical page.

The translator keeps four recent translations in a small fully associative cache. On a miss it issues one word read to memory. Requests are accepted one at a time, and each request gets a one-cycle response carrying an address and an error code.

Software programs three registers through a write port:
- the table base register: page-aligned table address in bits 31:12, page count in bits 11:0;
- the aperture base register: only bits 31:28 are used;
- the control register.

Translation does not flush on a single control bit. Two four-word write patterns on the control register are recognised instead:
- the first pattern empties the cache;
- the second pattern shuts translation off, provided the bus reports idle when its final word arrives.

Top module: `gart_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_valid is 0, and translation is disabled.
- R2: Translation is enabled by any control write with bit 8 set. While it is disabled, each request is answered in the cycle after acceptance with rsp_err = 1 and rsp_addr = 0, and no memory read is made.
- R3: While enabled, a request whose bits 31:28 differ from aperture base bits 31:28 is answered in the cycle after acceptance. The response has rsp_err = 0 and rsp_addr equal to the request address, and no memory read is made.
- R4: The page index is request bits 27:12. An aperture address whose index is greater than or equal to table base bits 11:0 gets rsp_err = 2 and causes no memory read.
- R5: On a cache miss, mem_rd_addr is {table base 31:12, 12'h000} + 4 × index. mem_rd_valid and mem_rd_addr hold steady until mem_rd_ack is high.
- R6: The fetched word d is byte-swapped to s = {d[7:0], d[15:8], d[23:16], d[31:24]}. When s[0] = 1, the response arrives the cycle after the ack, with rsp_err = 0 and rsp_addr = {s[31:12], request bits 11:0}.
- R7: A swapped entry with s[0] = 0 gives rsp_err = 3 and rsp_addr = 0. It is not cached, so a repeat request fetches again.
- R8: A valid fetched entry is cached. A later request to the same page is answered in the cycle after acceptance with no memory read, and rsp_valid lasts exactly one cycle.
- R9: The cache holds 4 pages and replaces them round robin from slot 0 after a flush. When a fifth distinct page is filled, the first page filled is evicted and the second is kept.
- R10: The control writes 0x101, 0x100, 0x10100, 0x100, arriving consecutively on the control register, empty the cache and reset the replacement pointer. Translation stays enabled.
- R11: A control sequence that breaks the pattern, such as 0x101, 0x100, 0x100, 0x100, leaves cached pages intact. A lone control write of 0 does not disable translation.
- R12: The control writes 0x101, 0, 0x10000, 0 disable translation and empty the cache, but only when bus_idle is 1 during the final write. If bus_idle is 0 then, translation stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 table base, 1 aperture base, 2 control |
| reg_wr_data | input | 32 | Register write data |
| bus_idle | input | 1 | Bus idle status, gates the shutdown pattern |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_err | output | 2 | 0 ok, 1 disabled, 2 out of range, 3 invalid entry |
| mem_rd_valid | output | 1 | Table word read request |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Table word as stored in memory |

## Verification
The hardest cases to reach are replacement order and flush recognition. The cache contents cannot be seen directly, so they show only through whether a request triggers a memory read. The stimulus first runs the flush pattern to put the replacement pointer at slot 0. It then fills five distinct pages and probes the second page before the first, so that probing does not itself evict the page under test. The flush and shutdown checks use the same probing. Each pattern is sent broken and then complete, and the shutdown pattern is sent once with the idle input low and once with it high; after each, the bench watches whether a cached page still avoids a fetch.

// File: rtl/gart_pkg.sv
package gart_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} st_t;
    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_DIS   = 2'd1,
        ERR_RANGE = 2'd2,
        ERR_INV   = 2'd3
    } err_t;

    localparam logic [31:0] CTL_INVAL = 32'h0000_0001;
    localparam logic [31:0] CTL_EN    = 32'h0000_0100;
    localparam logic [31:0] CTL_RST2X = 32'h0001_0000;
    localparam int          CTL_EN_BIT = 8;

    localparam logic [1:0] SEL_TBASE = 2'd0;
    localparam logic [1:0] SEL_APER  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    function automatic logic [31:0] swap32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction
endpackage

// File: rtl/gart_seq_det.sv
module gart_seq_det #(
    parameter logic [31:0] C0 = 32'h0,
    parameter logic [31:0] C1 = 32'h0,
    parameter logic [31:0] C2 = 32'h0,
    parameter logic [31:0] C3 = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        allow,
    output logic        fire
);
    logic [3:0][31:0] codes;
    assign codes = {C3, C2, C1, C0};

    logic [1:0] step_d, step_q;

    always_comb begin
        step_d = step_q;
        fire   = 1'b0;
        if (wr_en) begin
            if (wr_data == codes[step_q]) begin
                if (step_q == 2'd3) begin
                    fire   = allow;
                    step_d = 2'd0;
                end else begin
                    step_d = step_q + 2'd1;
                end
            end else begin
                step_d = (wr_data == codes[0]) ? 2'd1 : 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= 2'd0;
        else        step_q <= step_d;
    end
endmodule

// File: rtl/gart_tlb.sv
module gart_tlb #(
    parameter int N     = 4,
    parameter int TAG_W = 16,
    parameter int DAT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [DAT_W-1:0] hit_dat,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DAT_W-1:0] fill_dat
);
    localparam int PTR_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][TAG_W-1:0] tag;
        logic [N-1:0][DAT_W-1:0] dat;
        logic [PTR_W-1:0]        ptr;
    } tlb_s;

    tlb_s d, q;
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = q.vld[i] && (q.tag[i] == lk_tag);
    end

    always_comb begin
        hit_dat = '0;
        for (int i = 0; i < N; i++)
            if (match[i]) hit_dat = hit_dat | q.dat[i];
    end
    assign hit = |match;

    always_comb begin
        d = q;
        if (flush) begin
            d.vld = '0;
            d.ptr = '0;
        end else if (fill_en) begin
            d.vld[q.ptr] = 1'b1;
            d.tag[q.ptr] = fill_tag;
            d.dat[q.ptr] = fill_dat;
            d.ptr        = (q.ptr == PTR_W'(N - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gart_xlat.sv
module gart_xlat #(
    parameter int PAGE_SHIFT = 12,
    parameter int APER_BITS  = 4,
    parameter int CACHE_N    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_wr_sel,
    input  logic [31:0] reg_wr_data,
    input  logic        bus_idle,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_addr,
    output logic [1:0]  rsp_err,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [31:0] mem_rd_data
);
    import gart_pkg::*;

    localparam int AW    = 32;
    localparam int IDX_W = AW - APER_BITS - PAGE_SHIFT;
    localparam int PG_W  = AW - PAGE_SHIFT;

    typedef struct packed {
        st_t                   st;
        logic [APER_BITS-1:0]  aper;
        logic [AW-1:0]         tbase;
        logic                  en;
        logic [IDX_W-1:0]      idx;
        logic [PAGE_SHIFT-1:0] off;
        logic [AW-1:0]         raddr;
        err_t                  rerr;
    } xs_t;

    xs_t d, q;

    logic ctl_wr, flush_fire, shut_fire;
    logic [IDX_W-1:0] req_idx;
    logic [PG_W-1:0]  hit_page;
    logic             hit;
    logic             fill_en;
    logic [AW-1:0]    swapped;

    assign ctl_wr  = reg_wr_en && (reg_wr_sel == SEL_CTRL);
    assign req_idx = req_addr[AW-APER_BITS-1:PAGE_SHIFT];
    assign swapped = swap32(mem_rd_data);

    gart_seq_det #(
        .C0(CTL_EN | CTL_INVAL), .C1(CTL_EN),
        .C2(CTL_EN | CTL_RST2X), .C3(CTL_EN)
    ) u_flush_det (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(reg_wr_data),
        .allow(1'b1), .fire(flush_fire)
    );

    gart_seq_det #(
        .C0(CTL_EN | CTL_INVAL), .C1(32'h0),
        .C2(CTL_RST2X),          .C3(32'h0)
    ) u_shut_det (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(reg_wr_data),
        .allow(bus_idle), .fire(shut_fire)
    );

    gart_tlb #(.N(CACHE_N), .TAG_W(IDX_W), .DAT_W(PG_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush_fire | shut_fire),
        .lk_tag(req_idx), .hit(hit), .hit_dat(hit_page),
        .fill_en(fill_en), .fill_tag(q.idx), .fill_dat(swapped[AW-1:PAGE_SHIFT])
    );

    always_comb begin
        d       = q;
        fill_en = 1'b0;

        if (reg_wr_en) begin
            case (reg_wr_sel)
                SEL_TBASE: d.tbase = reg_wr_data;
                SEL_APER:  d.aper  = reg_wr_data[AW-1:AW-APER_BITS];
                default: ;
            endcase
        end
        if (ctl_wr && reg_wr_data[CTL_EN_BIT]) d.en = 1'b1;
        if (shut_fire)                         d.en = 1'b0;

        case (q.st)
            ST_IDLE: if (req_valid) begin
                d.idx = req_idx;
                d.off = req_addr[PAGE_SHIFT-1:0];
                d.st  = ST_RESP;
                if (!q.en) begin
                    d.rerr  = ERR_DIS;
                    d.raddr = '0;
                end else if (req_addr[AW-1:AW-APER_BITS] != q.aper) begin
                    d.rerr  = ERR_NONE;
                    d.raddr = req_addr;
                end else if ({{(IDX_W-PAGE_SHIFT){1'b0}}, q.tbase[PAGE_SHIFT-1:0]} <= req_idx) begin
                    d.rerr  = ERR_RANGE;
                    d.raddr = '0;
                end else if (hit) begin
                    d.rerr  = ERR_NONE;
                    d.raddr = {hit_page, req_addr[PAGE_SHIFT-1:0]};
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: if (mem_rd_ack) begin
                d.st = ST_RESP;
                if (swapped[0]) begin
                    fill_en = 1'b1;
                    d.rerr  = ERR_NONE;
                    d.raddr = {swapped[AW-1:PAGE_SHIFT], q.off};
                end else begin
                    d.rerr  = ERR_INV;
                    d.raddr = '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.rerr <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == ST_IDLE);
    assign rsp_valid    = (q.st == ST_RESP);
    assign rsp_addr     = q.raddr;
    assign rsp_err      = q.rerr;
    assign mem_rd_valid = (q.st == ST_FETCH);
    assign mem_rd_addr  = {q.tbase[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}}
                        + {{(AW-IDX_W-2){1'b0}}, q.idx, 2'b00};
endmodule

// File: rtl/gart_xlat_chk.sv
module gart_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic [1:0]  rsp_err,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ack,
    input logic [31:0] mem_rd_data
);
    import gart_pkg::*;
    logic [31:0] sw;
    assign sw = swap32(mem_rd_data);

    p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ack |=> mem_rd_valid && $stable(mem_rd_addr));

    p_fetch_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

    p_valid_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && mem_rd_ack && sw[0] |=>
        rsp_valid && rsp_err == 2'd0 && rsp_addr[31:12] == $past(sw[31:12]));

    p_invalid_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && mem_rd_ack && !sw[0] |=>
        rsp_valid && rsp_err == 2'd3 && rsp_addr == 32'h0);

    p_one_cycle_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && mem_rd_valid));
endmodule

bind gart_xlat gart_xlat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_err(rsp_err), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
);

// File: tb/gart_xlat_test.sv
`timescale 1ns/1ps
module gart_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        bus_idle = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_rd_valid;
    logic [31:0] rsp_addr, mem_rd_addr;
    logic [1:0]  rsp_err;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    gart_xlat uut (.*);

    localparam logic [31:0] TB_BASE = 32'h0010_0000;

    function automatic logic [31:0] le(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic ctl4(input logic [31:0] a, b, c, e);
        wr(2'd2, a); wr(2'd2, b); wr(2'd2, c); wr(2'd2, e);
    endtask

    // one request; table word 'entry' (logical value) is served if fetched
    task automatic xlat(input logic [31:0] a, input bit exp_fetch, input logic [31:0] entry,
                        input logic [1:0] exp_err, input logic [31:0] exp_pa, input string tag);
        bit fetched = 0;
        logic [31:0] faddr = '0;
        logic [31:0] exp_fa;
        exp_fa = TB_BASE + {14'h0, a[27:12], 2'b00};
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (mem_rd_valid) begin
            fetched = 1;
            faddr = mem_rd_addr;
            @(negedge clk);
            chk(mem_rd_valid && mem_rd_addr == faddr, {tag, " R5 fetch held"}, mem_rd_addr, faddr);
            mem_rd_ack = 1'b1; mem_rd_data = le(entry);
            @(negedge clk);
            mem_rd_ack = 1'b0;
        end
        chk(fetched == exp_fetch, {tag, " fetch made"}, 32'(fetched), 32'(exp_fetch));
        if (fetched && exp_fetch)
            chk(faddr == exp_fa, {tag, " R5 fetch address"}, faddr, exp_fa);
        chk(rsp_valid, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_err == exp_err, {tag, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
        chk(rsp_addr == exp_pa, {tag, " rsp_addr"}, rsp_addr, exp_pa);
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R8 rsp one cycle"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        wr(2'd0, TB_BASE | 32'd8);
        wr(2'd1, 32'h3000_0000);
        xlat(32'h3000_1000, 0, 0, 2'd1, 32'h0, "R1 R2 disabled after reset");
    endtask

    task automatic t_basic;
        wr(2'd2, 32'h0000_0100);
        xlat(32'h4000_1234, 0, 0, 2'd0, 32'h4000_1234, "R3 passthrough");
        xlat(32'h3000_8000, 0, 0, 2'd2, 32'h0, "R4 index == size");
        xlat(32'h3000_5ABC, 1, 32'h1234_5001, 2'd0, 32'h1234_5ABC, "R6 miss fill");
        xlat(32'h3000_5010, 0, 0, 2'd0, 32'h1234_5010, "R8 hit");
        xlat(32'h3000_7FFF, 1, 32'h7700_0001, 2'd0, 32'h7700_0FFF, "R4 last index");
        xlat(32'h3000_3000, 1, 32'h5555_5000, 2'd3, 32'h0, "R7 invalid entry");
        xlat(32'h3000_3004, 1, 32'h5555_5000, 2'd3, 32'h0, "R7 not cached");
    endtask

    task automatic t_rr;
        ctl4(32'h101, 32'h100, 32'h10100, 32'h100);
        for (int i = 0; i < 5; i++)
            xlat(32'h3000_0000 + 32'(i << 12), 1, 32'h0A00_0001 | 32'(i << 12),
                 2'd0, 32'h0A00_0000 | 32'(i << 12), "R9 fill");
        xlat(32'h3000_1040, 0, 0, 2'd0, 32'h0A00_1040, "R9 second kept");
        xlat(32'h3000_0040, 1, 32'h0A00_0001, 2'd0, 32'h0A00_0040, "R9 first evicted");
    endtask

    task automatic t_flush;
        ctl4(32'h101, 32'h100, 32'h100, 32'h100);
        xlat(32'h3000_2008, 0, 0, 2'd0, 32'h0A00_2008, "R11 broken sequence keeps cache");
        ctl4(32'h101, 32'h100, 32'h10100, 32'h100);
        xlat(32'h3000_2008, 1, 32'h0A00_2001, 2'd0, 32'h0A00_2008, "R10 flush refetch");
    endtask

    task automatic t_shut;
        wr(2'd2, 32'h0);
        xlat(32'h3000_2000, 0, 0, 2'd0, 32'h0A00_2000, "R11 lone zero keeps enable");
        bus_idle = 1'b0;
        ctl4(32'h101, 32'h0, 32'h10000, 32'h0);
        xlat(32'h3000_2000, 0, 0, 2'd0, 32'h0A00_2000, "R12 not idle ignored");
        bus_idle = 1'b1;
        ctl4(32'h101, 32'h0, 32'h10000, 32'h0);
        xlat(32'h3000_2000, 0, 0, 2'd1, 32'h0, "R12 shutdown disables");
        wr(2'd2, 32'h100);
        xlat(32'h3000_2000, 1, 32'h0A00_2001, 2'd0, 32'h0A00_2000, "R12 cache emptied");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rr();
        t_flush();
        t_shut();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule